// File: doc/BRIEF.md
# Latched Event Counter Peripheral

This block sits on the byte-wide data bus of an 8-bit processor and keeps four 64-bit running counts of what the processor does: clock cycles spent, ordinary instructions retired, maskable interrupt entries and non-maskable interrupt entries. It also receives two externally produced time values. One is a 64-bit nanosecond time. The other is a split form with whole seconds in the upper half and nanoseconds within that second in the lower half. The block neither generates nor checks these time values.

Software cannot read a 64-bit value atomically one byte at a time, so the block snapshots instead. A write to the snapshot register copies every live count and both time inputs into a bank of shadow registers in one clock edge. A selector register then picks which shadow appears in an eight-byte little-endian read window. Software writes the snapshot register once and sets the selector. It can then read any number of bytes, and all of them come from the same instant. A `periph_hit` output tells the surrounding bus fabric that an address belongs to the block and must not reach memory.

Top module: `latched_event_counter`

## Requirements
- R1: `periph_hit` is high exactly for addresses BASE_ADDR through BASE_ADDR+9 (default 0xFFC0..0xFFC9). Outside that range `bus_rdata` reads 0x00 and writes change no state of the block.
- R2: Offset 0 is the snapshot trigger. A write with any data value takes a snapshot, and a read at offset 0 returns 0x00.
- R3: Offset 1 is an 8-bit selector that reads back the last byte written to it and holds its value between writes.
- R4: Offsets 2 through 9 read byte 0 (least significant) through byte 7 (most significant) of the selected shadow register.
- R5: Selector codes: 0x00 cycle count, 0x01 instruction count, 0x02 maskable interrupt count, 0x03 non-maskable interrupt count, 0x80 nanosecond time, 0x81 split time (seconds in bits 63:32, nanoseconds in bits 31:0).
- R6: Any selector value other than the six codes in R5 makes every window byte (offsets 2..9) read 0x00.
- R7: A snapshot loads all six shadow registers on the same clock edge. The shadow registers keep their values until the next snapshot, whatever the live counts or time inputs do in between.
- R8: After a synchronous active-low reset, the selector, all live counts and all shadow registers are zero, so every readable offset returns 0x00.
- R9: If `time_valid` is low on the snapshot cycle, both time shadow registers are loaded with all ones. The four count shadows load normally.
- R10: Each cycle with `step_valid` high adds `step_cycles` (0..15) to the cycle count. It also adds one to the instruction count when neither `irq_taken` nor `nmi_taken` is high.
- R11: A step with `irq_taken` high and `nmi_taken` low adds one to the maskable count and not to the instruction count. A step with `nmi_taken` high adds one to the non-maskable count only, even when `irq_taken` is also high. The interrupt flags have no effect while `step_valid` is low.
- R12: When a step and a snapshot fall in the same cycle, the shadows receive the counts from before that step, and the step appears in the live counts afterwards.
- R13: Writes to offsets 2..9 change neither the selector nor any shadow register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Byte address of the current access |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| periph_hit | output | 1 | Address falls inside the block's register window |
| step_valid | input | 1 | One processor step (instruction or interrupt entry) completed this cycle |
| step_cycles | input | 4 | Clock cycles taken by that step |
| irq_taken | input | 1 | The step was a maskable interrupt entry |
| nmi_taken | input | 1 | The step was a non-maskable interrupt entry |
| time_ns | input | 64 | Current time in nanoseconds |
| time_split | input | 64 | Current time as seconds (63:32) and nanoseconds (31:0) |
| time_valid | input | 1 | The time inputs are trustworthy this cycle |

## Verification
On every cycle, the embedded properties check four things. Shadows and the selector hold when nothing writes them. An idle cycle leaves all live counts unchanged. An interrupt step never advances the instruction count, and a simultaneous IRQ and NMI advances only the NMI count. Bytes outside the window, the trigger offset and unknown selector codes always read zero. The check that an invalid time source loads all ones is also continuous. The values themselves can only be shown by the bench's reference model on every clock: the exact sums in each count, the byte order in the window, and the pre-step values captured when a step coincides with a snapshot.

// File: rtl/evcnt_pkg.sv
// Package: shared constants, source indices and selector decode for the
// latched event counter. Assumes six shadow sources: four counts, two times.
package evcnt_pkg;

    // Shadow source slots; count slots 0..3 line up with the live counters.
    typedef enum logic [2:0] {
        SRC_CYC   = 3'd0,
        SRC_INS   = 3'd1,
        SRC_IRQ   = 3'd2,
        SRC_NMI   = 3'd3,
        SRC_NS    = 3'd4,
        SRC_SPLIT = 3'd5
    } src_e;

    localparam int NUM_LIVE = 4;
    localparam int NUM_SRC  = 6;

    // Sources fed by the external time inputs.
    localparam logic [NUM_SRC-1:0] TIME_SRC_MASK = 6'b11_0000;

    // Register offsets inside the window.
    localparam int OFS_TRIGGER = 0;
    localparam int OFS_SELECT  = 1;
    localparam int OFS_WINDOW  = 2;

    // Selector codes visible to software.
    localparam logic [7:0] CODE_CYC   = 8'h00;
    localparam logic [7:0] CODE_INS   = 8'h01;
    localparam logic [7:0] CODE_IRQ   = 8'h02;
    localparam logic [7:0] CODE_NMI   = 8'h03;
    localparam logic [7:0] CODE_NS    = 8'h80;
    localparam logic [7:0] CODE_SPLIT = 8'h81;

    typedef struct packed {
        logic known;
        src_e src;
    } sel_dec_t;

    // Map a selector code to a shadow slot; unknown codes flag known=0.
    function automatic sel_dec_t decode_select(input logic [7:0] code);
        sel_dec_t d;
        d.known = 1'b1;
        d.src   = SRC_CYC;
        case (code)
            CODE_CYC:   d.src = SRC_CYC;
            CODE_INS:   d.src = SRC_INS;
            CODE_IRQ:   d.src = SRC_IRQ;
            CODE_NMI:   d.src = SRC_NMI;
            CODE_NS:    d.src = SRC_NS;
            CODE_SPLIT: d.src = SRC_SPLIT;
            default:    d.known = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/evcnt_live.sv
// Module: evcnt_live
// Keeps the four free-running counts (cycles, instructions, maskable and
// non-maskable interrupt entries). Assumes at most one step per clock, and
// treats the interrupt flags as qualifiers of that step; NMI outranks IRQ.
module evcnt_live
    import evcnt_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int CYC_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              step_valid_i,
    input  logic [CYC_W-1:0]                  step_cycles_i,
    input  logic                              irq_taken_i,
    input  logic                              nmi_taken_i,
    output logic [NUM_LIVE-1:0][CNT_W-1:0]    live_o
);

    logic                              take_nmi;
    logic                              take_irq;
    logic                              take_ins;
    logic [NUM_LIVE-1:0][CNT_W-1:0]    incr;

    // Classify the completed step into exactly one event kind.
    always_comb begin
        take_nmi = step_valid_i & nmi_taken_i;
        take_irq = step_valid_i & irq_taken_i & ~nmi_taken_i;
        take_ins = step_valid_i & ~irq_taken_i & ~nmi_taken_i;
    end

    // Per-counter increment amounts.
    always_comb begin
        incr          = '0;
        incr[SRC_CYC] = step_valid_i ? {{(CNT_W-CYC_W){1'b0}}, step_cycles_i} : '0;
        incr[SRC_INS] = {{(CNT_W-1){1'b0}}, take_ins};
        incr[SRC_IRQ] = {{(CNT_W-1){1'b0}}, take_irq};
        incr[SRC_NMI] = {{(CNT_W-1){1'b0}}, take_nmi};
    end

    for (genvar g = 0; g < NUM_LIVE; g++) begin : g_cnt
        // Accumulate this counter's increment every clock.
        always_ff @(posedge clk) begin
            if (!rst_n) live_o[g] <= '0;
            else        live_o[g] <= live_o[g] + incr[g];
        end
    end

    // R10: no step, no movement in any count.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid_i |=> $stable(live_o));

    // R11: an interrupt step leaves the instruction count untouched.
    p_irq_not_ins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_i && (irq_taken_i || nmi_taken_i)) |=> $stable(live_o[SRC_INS]));

    // R11: NMI wins over a simultaneous IRQ.
    p_nmi_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_i && nmi_taken_i) |=> $stable(live_o[SRC_IRQ]));

endmodule

// File: rtl/evcnt_shadow.sv
// Module: evcnt_shadow
// Bank of shadow registers, one per source, all loaded on the same edge when
// the snapshot strobe is high. Time slots load all ones if the time source
// flags itself invalid. Assumes the strobe is a single-cycle pulse.
module evcnt_shadow
    import evcnt_pkg::*;
#(
    parameter int                  CNT_W    = 64,
    parameter int                  SRC_N    = NUM_SRC,
    parameter logic [SRC_N-1:0]    TIME_SEL = TIME_SRC_MASK
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           snap_i,
    input  logic                           time_ok_i,
    input  logic [SRC_N-1:0][CNT_W-1:0]    src_i,
    output logic [SRC_N-1:0][CNT_W-1:0]    shd_o
);

    for (genvar g = 0; g < SRC_N; g++) begin : g_slot
        if (TIME_SEL[g]) begin : g_time
            // Capture a time value, or all ones when the source is invalid.
            always_ff @(posedge clk) begin
                if (!rst_n)      shd_o[g] <= '0;
                else if (snap_i) shd_o[g] <= time_ok_i ? src_i[g] : '1;
            end
        end else begin : g_count
            // Capture a live count.
            always_ff @(posedge clk) begin
                if (!rst_n)      shd_o[g] <= '0;
                else if (snap_i) shd_o[g] <= src_i[g];
            end
        end
    end

    // R7: shadows only move on a snapshot.
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(shd_o));

    // R9: an invalid time source gives all ones in the time slots.
    p_time_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_i && !time_ok_i) |=> (shd_o[SRC_NS] == '1 && shd_o[SRC_SPLIT] == '1));

endmodule

// File: rtl/evcnt_readout.sv
// Module: evcnt_readout
// Picks the shadow named by the selector and returns the byte addressed by
// the window offset, least significant byte at the lowest window offset.
// Purely combinational; assumes offsets outside the window are filtered by
// the caller but returns zero for them anyway.
module evcnt_readout
    import evcnt_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int SRC_N = NUM_SRC,
    parameter int OFS_W = 4
) (
    input  logic [7:0]                     select_i,
    input  logic [OFS_W-1:0]               ofs_i,
    input  logic [SRC_N-1:0][CNT_W-1:0]    shd_i,
    output logic [7:0]                     byte_o
);

    localparam int WIN_BYTES = CNT_W / 8;

    sel_dec_t          dec;
    logic [CNT_W-1:0]  picked;

    // Decode the selector and route the chosen shadow, zero when unknown.
    always_comb begin
        dec    = decode_select(select_i);
        picked = '0;
        for (int s = 0; s < SRC_N; s++) begin
            if (dec.known && dec.src == src_e'(s)) picked = shd_i[s];
        end
    end

    // Extract the byte that the window offset points at.
    always_comb begin
        byte_o = '0;
        for (int k = 0; k < WIN_BYTES; k++) begin
            if (ofs_i == OFS_W'(k + OFS_WINDOW)) byte_o = picked[k*8 +: 8];
        end
    end

endmodule

// File: rtl/latched_event_counter.sv
// Module: latched_event_counter (top)
// Decodes the ten-byte register window, holds the selector, and ties the
// live counters, shadow bank and readout together. Reads are combinational
// from address and state; writes take effect on the clock edge. Assumes one
// bus access per cycle.
module latched_event_counter
    import evcnt_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'hFFC0,
    parameter int                 CNT_W     = 64,
    parameter int                 CYC_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              periph_hit,
    input  logic              step_valid,
    input  logic [3:0]        step_cycles,
    input  logic              irq_taken,
    input  logic              nmi_taken,
    input  logic [63:0]       time_ns,
    input  logic [63:0]       time_split,
    input  logic              time_valid
);

    localparam int WIN_BYTES = CNT_W / 8;
    localparam int REG_SPAN  = WIN_BYTES + OFS_WINDOW;
    localparam int OFS_W     = $clog2(REG_SPAN);

    logic [ADDR_W-1:0]                 rel_addr;
    logic [OFS_W-1:0]                  ofs;
    logic                              snap;
    logic                              sel_wr;
    logic [7:0]                        select_q;
    logic [7:0]                        win_byte;
    logic [NUM_LIVE-1:0][CNT_W-1:0]    live;
    logic [NUM_SRC-1:0][CNT_W-1:0]     src_all;
    logic [NUM_SRC-1:0][CNT_W-1:0]     shd;

    // Window decode: in range when at or above base and within the span.
    always_comb begin
        rel_addr   = bus_addr - BASE_ADDR;
        periph_hit = (bus_addr >= BASE_ADDR) && (rel_addr < ADDR_W'(REG_SPAN));
        ofs        = rel_addr[OFS_W-1:0];
        snap       = bus_wr && periph_hit && (ofs == OFS_W'(OFS_TRIGGER));
        sel_wr     = bus_wr && periph_hit && (ofs == OFS_W'(OFS_SELECT));
    end

    // Selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)      select_q <= '0;
        else if (sel_wr) select_q <= bus_wdata;
    end

    evcnt_live #(
        .CNT_W (CNT_W),
        .CYC_W (CYC_W)
    ) live_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_valid_i  (step_valid),
        .step_cycles_i (step_cycles),
        .irq_taken_i   (irq_taken),
        .nmi_taken_i   (nmi_taken),
        .live_o        (live)
    );

    // Gather every snapshot source: time slots above the four counts.
    assign src_all = {time_split, time_ns, live};

    evcnt_shadow #(
        .CNT_W    (CNT_W),
        .SRC_N    (NUM_SRC),
        .TIME_SEL (TIME_SRC_MASK)
    ) shadow_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_i    (snap),
        .time_ok_i (time_valid),
        .src_i     (src_all),
        .shd_o     (shd)
    );

    evcnt_readout #(
        .CNT_W (CNT_W),
        .SRC_N (NUM_SRC),
        .OFS_W (OFS_W)
    ) readout_i (
        .select_i (select_q),
        .ofs_i    (ofs),
        .shd_i    (shd),
        .byte_o   (win_byte)
    );

    // Read data mux: zero outside the window and at the trigger offset.
    always_comb begin
        bus_rdata = '0;
        if (periph_hit) begin
            if (ofs == OFS_W'(OFS_SELECT))      bus_rdata = select_q;
            else if (ofs >= OFS_W'(OFS_WINDOW)) bus_rdata = win_byte;
        end
    end

    // R1: nothing is driven for addresses outside the window.
    p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_hit |-> bus_rdata == 8'h00);

    // R2: the trigger offset always reads zero.
    p_trigger_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_hit && rel_addr == ADDR_W'(OFS_TRIGGER)) |-> bus_rdata == 8'h00);

    // R3: the selector holds unless written at its own offset.
    p_select_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && periph_hit && rel_addr == ADDR_W'(OFS_SELECT)) |=> $stable(select_q));

    // R6: unknown selector codes read zero through the whole window.
    p_unknown_code_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_hit && rel_addr >= ADDR_W'(OFS_WINDOW) && !decode_select(select_q).known)
        |-> bus_rdata == 8'h00);

endmodule

// File: tb/latched_event_counter_tb_top.sv
`timescale 1ns/1ps
module latched_event_counter_tb_top;

    localparam logic [15:0] BASE = 16'hFFC0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        periph_hit;
    logic        step_valid;
    logic [3:0]  step_cycles;
    logic        irq_taken;
    logic        nmi_taken;
    logic [63:0] time_ns;
    logic [63:0] time_split;
    logic        time_valid;

    int vectors  = 0;
    int miscomp  = 0;
    bit finished = 0;

    // Reference model state.
    bit          m_valid = 0;
    logic [63:0] m_live [4];
    logic [63:0] m_shd  [6];
    logic [7:0]  m_sel;

    always #2.5 clk = ~clk;

    latched_event_counter dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_hit(periph_hit),
        .step_valid(step_valid), .step_cycles(step_cycles), .irq_taken(irq_taken),
        .nmi_taken(nmi_taken), .time_ns(time_ns), .time_split(time_split),
        .time_valid(time_valid)
    );

    function automatic bit in_win(input logic [15:0] a);
        return (a >= BASE) && (a <= BASE + 16'd9);
    endfunction

    function automatic logic [63:0] sel_value();
        case (m_sel)
            8'h00: return m_shd[0];
            8'h01: return m_shd[1];
            8'h02: return m_shd[2];
            8'h03: return m_shd[3];
            8'h80: return m_shd[4];
            8'h81: return m_shd[5];
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [15:0] a);
        int o;
        logic [63:0] v;
        if (!in_win(a)) return 8'h00;
        o = int'(a - BASE);
        if (o == 0) return 8'h00;
        if (o == 1) return m_sel;
        v = sel_value();
        return v[(o-2)*8 +: 8];
    endfunction

    // Advance the model exactly as the coming clock edge should.
    task automatic model_edge();
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_live[i] = 64'd0;
            for (int i = 0; i < 6; i++) m_shd[i] = 64'd0;
            m_sel   = 8'h00;
            m_valid = 1;
            return;
        end
        if (bus_wr && bus_addr == BASE) begin
            for (int i = 0; i < 4; i++) m_shd[i] = m_live[i];
            m_shd[4] = time_valid ? time_ns    : {64{1'b1}};
            m_shd[5] = time_valid ? time_split : {64{1'b1}};
        end
        if (bus_wr && bus_addr == BASE + 16'd1) m_sel = bus_wdata;
        if (step_valid) begin
            m_live[0] = m_live[0] + 64'(step_cycles);
            if (nmi_taken)      m_live[3] = m_live[3] + 64'd1;
            else if (irq_taken) m_live[2] = m_live[2] + 64'd1;
            else                m_live[1] = m_live[1] + 64'd1;
        end
    endtask

    // One cycle: compare outputs after settling, step the model, move on.
    task automatic tick(input string req);
        logic [7:0] er;
        #1;
        if (m_valid && rst_n) begin
            er = exp_rdata(bus_addr);
            vectors++;
            if (bus_rdata !== er || periph_hit !== in_win(bus_addr)) begin
                miscomp++;
                $display("FAIL %s addr=%h rdata=%h exp=%h hit=%b exp_hit=%b",
                         req, bus_addr, bus_rdata, er, periph_hit, in_win(bus_addr));
            end
        end
        model_edge();
        @(negedge clk);
        bus_wr     = 1'b0;
        step_valid = 1'b0;
        irq_taken  = 1'b0;
        nmi_taken  = 1'b0;
        time_ns    = time_ns + 64'd7;
        time_split = {time_split[63:32] + 32'd1, time_split[31:0] + 32'd13};
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        tick(req);
    endtask

    task automatic read_all(input string req);
        for (int o = 0; o < 10; o++) begin
            bus_addr = BASE + 16'(o);
            tick(req);
        end
    endtask

    task automatic step(input logic [3:0] c, input bit irq, input bit nmi, input string req);
        step_valid = 1'b1; step_cycles = c; irq_taken = irq; nmi_taken = nmi;
        bus_addr = 16'h0200;
        tick(req);
    endtask

    task automatic read_sel(input logic [7:0] code, input string req);
        wr(BASE + 16'd1, code, req);
        read_all(req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            miscomp++;
            $display("FAIL watchdog (all requirements) run did not finish, exp=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = 16'h0000; bus_wr = 1'b0; bus_wdata = 8'h00;
        step_valid = 1'b0; step_cycles = 4'd0; irq_taken = 1'b0; nmi_taken = 1'b0;
        time_ns = 64'h0123_4567_89AB_CDEF; time_split = 64'h6500_0000_0000_1000;
        time_valid = 1'b1;
        @(negedge clk);
        tick("R8"); tick("R8");
        rst_n = 1'b1;

        // R8: everything reads zero after reset, before any snapshot.
        read_all("R8");
        read_sel(8'h80, "R8");

        // R10: instructions of varied lengths, then snapshot and read counts.
        step(4'd2, 0, 0, "R10"); step(4'd7, 0, 0, "R10"); step(4'd15, 0, 0, "R10");
        wr(BASE, 8'h5A, "R2");
        read_sel(8'h00, "R4");
        read_sel(8'h01, "R5");

        // R11: interrupt entries, including both flags together.
        step(4'd7, 1, 0, "R11"); step(4'd7, 0, 1, "R11"); step(4'd7, 1, 1, "R11");
        irq_taken = 1'b1; nmi_taken = 1'b1; bus_addr = 16'h0300; tick("R11");
        wr(BASE, 8'h00, "R11");
        read_sel(8'h02, "R11");
        read_sel(8'h03, "R11");
        read_sel(8'h01, "R11");

        // R12: step in the same cycle as the snapshot.
        step_valid = 1'b1; step_cycles = 4'd9; wr(BASE, 8'hFF, "R12");
        read_sel(8'h00, "R12");
        wr(BASE, 8'h01, "R12");
        read_sel(8'h00, "R12");

        // R5: both time forms from one instant.
        wr(BASE, 8'h33, "R5");
        read_sel(8'h80, "R5");
        read_sel(8'h81, "R5");

        // R9: invalid time source on a snapshot.
        time_valid = 1'b0; wr(BASE, 8'h44, "R9"); time_valid = 1'b1;
        read_sel(8'h80, "R9");
        read_sel(8'h81, "R9");
        read_sel(8'h01, "R9");

        // R6: codes next to the defined ones read zero.
        read_sel(8'h04, "R6");
        read_sel(8'h7F, "R6");
        read_sel(8'h82, "R6");
        read_sel(8'hFF, "R6");

        // R7: shadows hold while live counts keep moving.
        wr(BASE, 8'h00, "R7");
        for (int i = 0; i < 20; i++) step(4'(i), 0, 0, "R7");
        read_sel(8'h00, "R7");
        read_sel(8'h81, "R7");

        // R13: writes into the value window are ignored.
        wr(BASE + 16'd1, 8'h01, "R13");
        for (int o = 2; o < 10; o++) wr(BASE + 16'(o), 8'hA5, "R13");
        read_all("R13");

        // R1: accesses just outside the window, including a select-like write.
        wr(16'hFFBF, 8'h80, "R1"); wr(16'hFFCA, 8'h00, "R1"); wr(16'h00C1, 8'h81, "R1");
        bus_addr = 16'hFFBF; tick("R1");
        bus_addr = 16'hFFCA; tick("R1");
        read_all("R1");

        // R3: selector read-back of arbitrary bytes.
        for (int i = 0; i < 8; i++) begin
            wr(BASE + 16'd1, 8'($urandom), "R3");
            bus_addr = BASE + 16'd1; tick("R3");
        end

        // Mixed random traffic across all behaviours (R4 byte order included).
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            step_valid  = ($urandom_range(0, 2) != 0);
            step_cycles = 4'($urandom);
            irq_taken   = ($urandom_range(0, 5) == 0);
            nmi_taken   = ($urandom_range(0, 7) == 0);
            time_valid  = ($urandom_range(0, 9) != 0);
            if (r < 6) begin
                bus_addr = BASE + 16'($urandom_range(0, 9));
                tick("R4");
            end else if (r == 6) begin
                bus_addr = 16'($urandom);
                bus_wr = $urandom_range(0, 1) == 1; bus_wdata = 8'($urandom);
                tick("R1");
            end else if (r == 7) begin
                wr(BASE, 8'($urandom), "R7");
            end else begin
                case ($urandom_range(0, 6))
                    0: bus_wdata = 8'h00; 1: bus_wdata = 8'h01; 2: bus_wdata = 8'h02;
                    3: bus_wdata = 8'h03; 4: bus_wdata = 8'h80; 5: bus_wdata = 8'h81;
                    default: bus_wdata = 8'($urandom);
                endcase
                bus_addr = BASE + 16'd1; bus_wr = 1'b1;
                tick("R5");
            end
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule